// File: doc/BRIEF.md
# Strided Subset Copy Engine

This block prepares a readout window from a capture buffer held in a byte-wide synchronous SRAM. When it receives a start pulse, it builds a contiguous 1103-byte window starting at 0x4000. It first takes 500 bytes from the capture region (0x6000 to 0x7387) at the first stride. It then takes 500 more from a shifted origin at the second stride. Next it writes the fixed guard bytes 0x01, 0xFE, 0x80. Last, it duplicates 100 bytes of the window taken from 0x4320 onward. A host that reads the window can use the guard bytes and the duplicated stretch to detect a corrupted transfer.

The engine owns the single SRAM port. Each copied byte costs one read cycle followed by one write cycle, and the SRAM returns read data one clock after the address. Each guard byte costs one write cycle. The stride and shift controls arrive encoded as value plus one. When the window is complete, `done` pulses for one cycle. When a start is accepted, `rewind` pulses so that the readout pointer returns to 0x4000.

States: IDLE waits for `start` (IDLE→RD on start, which also pulses `rewind`). RD presents a source address (RD→WR always). WR writes the byte just read (WR→RD for the next copy, WR→SIG after the last second-subset byte, WR→DONE after the last tail byte). SIG writes the three guard bytes (SIG→RD after the third). DONE raises `done` (DONE→IDLE).

Top module: `strided_subset_copier`

## Requirements
- R1: Window byte 0x4000+i (i = 0..499) equals capture byte 0x6000 + i·s1, where s1 is the decoded first stride.
- R2: Window byte 0x41F4+i (i = 0..499) equals capture byte 0x6000 + 5·s1·sh + i·s2, where sh is the decoded shift and s2 is the decoded second stride.
- R3: Bytes 0x43E8, 0x43E9 and 0x43EA hold 0x01, 0xFE and 0x80, in that order.
- R4: Window byte 0x43EB+k (k = 0..99) equals the window byte at 0x4320+k.
- R5: Each control input code c decodes to c−1. A code of 0 decodes to 0.
- R6: A source offset beyond 4999 reads the last captured byte, 0x7387. Reads of the capture region never leave 0x6000..0x7387.
- R7: Every write is preceded by a read cycle, except guard-byte writes. No write lands outside 0x4000..0x444E.
- R8: `done` is a single-cycle pulse. It is high in the cycle that follows clock edge 2203 after the edge that samples `start` (the tail's last write completes at that edge).
- R9: `rewind` pulses in the first cycle after a start is accepted. A `start` asserted while busy is ignored.
- R10: During and after reset the block is idle: `mem_we`, `done` and `rewind` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request to rebuild the readout window |
| step1_code | input | 8 | First stride, encoded as value+1 |
| step2_code | input | 8 | Second stride, encoded as value+1 |
| shift_code | input | 8 | Second-subset shift, encoded as value+1 |
| mem_rdata | input | 8 | SRAM read data, valid one cycle after its address |
| mem_addr | output | 16 | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| done | output | 1 | Window complete, one-cycle pulse |
| rewind | output | 1 | Reset readout pointer to 0x4000, one-cycle pulse |

## Verification
The bench uses a shift and stride product that pushes the second subset past the end of the capture region. A design without the clamp would read beyond 0x7387 and return bytes that do not match. A stride of zero and codes of zero test the decode. A design that does not subtract one, or that wraps 0 to 255, would fetch the wrong bytes. A start pulse in the middle of a run must not restart or disturb the copy, so a design that re-arms while busy would miss the expected completion cycle. A design whose write is off by one cycle from its read latency would shift every window byte by one position.

// File: rtl/sxg_pkg.sv
package sxg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SIG,
        ST_DONE
    } sxg_state_e;

    typedef enum logic [1:0] {
        PH_SUB1,
        PH_SUB2,
        PH_TAIL
    } sxg_phase_e;

    localparam int SIG_LEN = 3;

    function automatic logic [7:0] guard_byte(input logic [1:0] idx);
        unique case (idx)
            2'd0:    return 8'h01;
            2'd1:    return 8'hFE;
            default: return 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/sxg_param_decode.sv
module sxg_param_decode #(
    parameter int PRM_W = 8,
    parameter int OFF_W = 19
) (
    input  logic [PRM_W-1:0] step1_code,
    input  logic [PRM_W-1:0] step2_code,
    input  logic [PRM_W-1:0] shift_code,
    output logic [PRM_W-1:0] step1,
    output logic [PRM_W-1:0] step2,
    output logic [OFF_W-1:0] base2_off
);
    logic [PRM_W-1:0] shift;

    function automatic logic [PRM_W-1:0] unbias(input logic [PRM_W-1:0] c);
        return (c == '0) ? '0 : c - PRM_W'(1);
    endfunction

    always_comb begin
        step1     = unbias(step1_code);
        step2     = unbias(step2_code);
        shift     = unbias(shift_code);
        base2_off = OFF_W'(5) * OFF_W'(step1) * OFF_W'(shift);
    end
endmodule

// File: rtl/sxg_src_clamp.sv
module sxg_src_clamp #(
    parameter int AW       = 16,
    parameter int OFF_W    = 19,
    parameter int SRC_BASE = 'h6000,
    parameter int SRC_LEN  = 5000
) (
    input  logic [OFF_W-1:0] off,
    output logic [AW-1:0]    addr
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SRC_LEN - 1);

    always_comb begin
        if (off > LAST_OFF)
            addr = AW'(SRC_BASE) + AW'(LAST_OFF);
        else
            addr = AW'(SRC_BASE) + AW'(off);
    end
endmodule

// File: rtl/strided_subset_copier.sv
module strided_subset_copier
    import sxg_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PRM_W    = 8,
    parameter int SRC_BASE = 'h6000,
    parameter int SRC_LEN  = 5000,
    parameter int DST_BASE = 'h4000,
    parameter int SUB_LEN  = 500,
    parameter int TAIL_SRC = 'h4320,
    parameter int TAIL_LEN = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PRM_W-1:0] step1_code,
    input  logic [PRM_W-1:0] step2_code,
    input  logic [PRM_W-1:0] shift_code,
    input  logic [7:0]       mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    output logic             done,
    output logic             rewind
);
    localparam int OFF_W = $clog2(5 * (2**PRM_W) * (2**PRM_W) + SUB_LEN * (2**PRM_W));
    localparam int CNT_W = $clog2(SUB_LEN + 1);
    localparam logic [CNT_W-1:0] SUB_LAST  = CNT_W'(SUB_LEN - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_LEN - 1);
    localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(SIG_LEN - 1);
    localparam int DST_END = DST_BASE + 2 * SUB_LEN + SIG_LEN + TAIL_LEN - 1;
    localparam int SRC_END = SRC_BASE + SRC_LEN - 1;

    sxg_state_e       st;
    sxg_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
    logic [AW-1:0]    dst;
    logic [PRM_W-1:0] s1_q, s2_q;
    logic [OFF_W-1:0] off2_q;

    logic [PRM_W-1:0] step1_d, step2_d;
    logic [OFF_W-1:0] off2_d;
    logic [AW-1:0]    src_addr;

    sxg_param_decode #(.PRM_W(PRM_W), .OFF_W(OFF_W)) u_decode (
        .step1_code (step1_code),
        .step2_code (step2_code),
        .shift_code (shift_code),
        .step1      (step1_d),
        .step2      (step2_d),
        .base2_off  (off2_d)
    );

    sxg_src_clamp #(.AW(AW), .OFF_W(OFF_W), .SRC_BASE(SRC_BASE), .SRC_LEN(SRC_LEN)) u_clamp (
        .off  (off),
        .addr (src_addr)
    );

    // State register and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            phase  <= PH_SUB1;
            cnt    <= '0;
            off    <= '0;
            dst    <= AW'(DST_BASE);
            s1_q   <= '0;
            s2_q   <= '0;
            off2_q <= '0;
            rewind <= 1'b0;
        end else begin
            rewind <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st     <= ST_RD;
                        phase  <= PH_SUB1;
                        cnt    <= '0;
                        off    <= '0;
                        dst    <= AW'(DST_BASE);
                        s1_q   <= step1_d;
                        s2_q   <= step2_d;
                        off2_q <= off2_d;
                        rewind <= 1'b1;
                    end
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    dst <= dst + AW'(1);
                    if (phase == PH_TAIL) begin
                        if (cnt == TAIL_LAST) begin
                            st <= ST_DONE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                            st  <= ST_RD;
                        end
                    end else if (cnt == SUB_LAST) begin
                        cnt <= '0;
                        if (phase == PH_SUB1) begin
                            phase <= PH_SUB2;
                            off   <= off2_q;
                            st    <= ST_RD;
                        end else begin
                            st <= ST_SIG;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        off <= off + OFF_W'((phase == PH_SUB1) ? s1_q : s2_q);
                        st  <= ST_RD;
                    end
                end
                ST_SIG: begin
                    dst <= dst + AW'(1);
                    if (cnt == SIG_LAST) begin
                        cnt   <= '0;
                        phase <= PH_TAIL;
                        st    <= ST_RD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_addr  = dst;
        mem_wdata = 8'h00;
        mem_we    = 1'b0;
        done      = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_RD: begin
                if (phase == PH_TAIL)
                    mem_addr = AW'(TAIL_SRC) + AW'(cnt);
                else
                    mem_addr = src_addr;
            end
            ST_WR: begin
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_SIG: begin
                mem_we    = 1'b1;
                mem_wdata = guard_byte(cnt[1:0]);
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assert_we_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= AW'(DST_BASE) && mem_addr <= AW'(DST_END)));

    assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR) |-> ($past(st) == ST_RD));

    assert_src_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD && phase != PH_TAIL) |->
            (mem_addr >= AW'(SRC_BASE) && mem_addr <= AW'(SRC_END)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rewind_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> (st == ST_RD && mem_addr == AW'(SRC_BASE) && !mem_we));

endmodule

// File: tb/tb_strided_subset_copier.sv
module tb_strided_subset_copier;
    localparam int WIN = 1103;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] step1_code = 8'd1, step2_code = 8'd1, shift_code = 8'd1;
    logic [7:0] mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we, done, rewind;

    int checks = 0;
    int fails  = 0;
    int stray  = 0;
    logic [7:0] win [WIN];
    logic [7:0] expw [WIN];

    always #10 clk = ~clk;

    strided_subset_copier dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .step1_code(step1_code), .step2_code(step2_code), .shift_code(shift_code),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .rewind(rewind)
    );

    function automatic logic [7:0] capb(int a);
        return 8'((a * 37) ^ (a >> 7));
    endfunction

    // SRAM model: synchronous read, one-cycle latency
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_addr >= 16'h4000 && mem_addr <= 16'h444E)
                win[int'(mem_addr) - 'h4000] <= mem_wdata;
            else
                stray <= stray + 1;
        end
        if (mem_addr >= 16'h6000)
            mem_rdata <= capb(int'(mem_addr));
        else if (mem_addr >= 16'h4000 && mem_addr <= 16'h444E)
            mem_rdata <= win[int'(mem_addr) - 'h4000];
        else
            mem_rdata <= 8'h00;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dec(int c);
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic region(input string req, input int lo, input int n);
        int bad = -1;
        for (int i = lo; i < lo + n; i++)
            if (bad < 0 && win[i] !== expw[i]) bad = i;
        if (bad < 0) check(req, 0, 0);
        else check(req, int'(win[bad]), int'(expw[bad]));
    endtask

    task automatic run_one(input int c1, input int c2, input int c3, input bit mid_start);
        int s1, s2, sh, n, st0;
        s1 = dec(c1); s2 = dec(c2); sh = dec(c3);
        for (int i = 0; i < 500; i++) begin
            int o1, o2;
            o1 = i * s1;           if (o1 > 4999) o1 = 4999;
            o2 = 5*s1*sh + i * s2; if (o2 > 4999) o2 = 4999;
            expw[i]       = capb('h6000 + o1);
            expw[500 + i] = capb('h6000 + o2);
        end
        expw[1000] = 8'h01; expw[1001] = 8'hFE; expw[1002] = 8'h80;
        for (int k = 0; k < 100; k++) expw[1003 + k] = expw['h320 + k];
        for (int i = 0; i < WIN; i++) win[i] = 8'hEE;
        st0 = stray;
        @(negedge clk);
        step1_code = 8'(c1); step2_code = 8'(c2); shift_code = 8'(c3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 rewind after start", int'(rewind), 1);
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (mid_start && n == 100) begin
                start = 1'b1; step1_code = 8'd7; step2_code = 8'd9; shift_code = 8'd3;
            end else start = 1'b0;
            if (mid_start && n == 100) check("R9 no rewind while busy", int'(rewind), 0);
        end
        check("R8 done latency", n, 2203);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
        region("R1 first subset", 0, 500);
        region("R2/R5/R6 second subset", 500, 500);
        region("R3 guard bytes", 1000, 3);
        region("R4 duplicated tail", 1003, 100);
        check("R7 writes inside window", stray - st0, 0);
    endtask

    // {step1_code, step2_code, shift_code}
    localparam logic [23:0] VEC [6] = '{
        24'h02_02_01,   // unit strides, no shift
        24'h0B_01_01,   // stride 10, second stride 0 (R5)
        24'h0B_03_02,   // shift 1
        24'h15_05_03,   // first subset clamps (R6)
        24'hFF_FF_FF,   // large offsets clamp (R6)
        24'h00_00_00    // zero codes decode to 0 (R5)
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset we", int'(mem_we), 0);
        check("R10 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset rewind", int'(rewind), 0);
        check("R10 idle after reset we", int'(mem_we), 0);
        for (int v = 0; v < 6; v++)
            run_one(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
        run_one(4, 6, 5, 1'b1);   // R9: start during busy is ignored
        repeat (4) @(negedge clk);
        check("R9 idle after run", int'(mem_we), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule